// File: doc/BRIEF.md
# Serial Host Message Port

This block is the slave end of a four-wire serial control link. A host microcontroller uses it to swap byte messages with an on-chip processor core. The host drives chip select, serial clock and serial data in. The block returns read data on a serial data out pin that has its own output-enable. It also drives an active-low interrupt-request line. That line tells the host a message from the core is waiting.

Each transaction opens with a 7-bit device address and a direction bit. If the address matches and the direction is write, the bytes that follow go into a receive FIFO, where the core collects them. If the address matches and the direction is read, the host clocks bytes out of a transmit FIFO that the core fills. If the address does not match, the rest of the transaction is ignored.

The block oversamples the serial pins with the system clock. The interrupt line is released only at one point: the seventh rising serial-clock edge of a read byte, when the transmit FIFO is empty. The release then holds until the next rising edge. If data turns up after the release, the line drops again. The host must then end the transaction and start a new read, because once the line has been released the current transaction returns only filler bytes.

Top module: `sspi_port`

## Requirements
- R1: After reset, irq_no is 1, sdo_oe_o is 0, both FIFOs report empty, neither reports full, and rx_ovf_o is 0.
- R2: A transaction whose first byte is {DEV_ADDR, 1'b0} (address in bits 7:1, bit 0 = 0 for write) pushes each following byte into the receive FIFO. Bytes are assembled MSB first from sdi_i, sampled on rising sclk_i. They leave the FIFO in arrival order; rx_data_o shows the head entry, and rx_rd_i pops it.
- R3: A transaction whose first byte is {DEV_ADDR, 1'b1} asserts sdo_oe_o. Each read byte is then shifted out MSB first, with sdo_o changing after falling sclk_i edges. The byte is taken from the transmit FIFO in write order at the last rising edge of the byte before it.
- R4: A transaction whose address field differs from DEV_ADDR pushes nothing, pops nothing, and keeps sdo_oe_o at 0.
- R5: When the core writes into the transmit FIFO while irq_no is high and no hold is active, irq_no goes low no later than two clock cycles after the write.
- R6: While irq_no is low, it goes high only at the 7th rising sclk_i edge of a read byte, and only if the transmit FIFO is empty at that moment. With data still queued, it stays low from byte to byte.
- R7: Once irq_no has gone high, it stays high until the next rising sclk_i edge, even if data arrives. It then goes low if data is pending. For the rest of that transaction, reads return 0x00 and do not pop; the pending byte is delivered by a fresh read transaction.
- R8: A received byte arriving while the receive FIFO holds FIFO_DEPTH entries is dropped and sets rx_ovf_o. rx_ovf_o stays set until reset.
- R9: Raising cs_ni ends the transaction: a partly shifted write byte is discarded and sdo_oe_o returns to 0.
- R10: rx_full_o and tx_full_o are 1 exactly when their FIFO holds FIFO_DEPTH (8) entries; the empty flags are 1 exactly at zero entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| irq_no | output | 1 | Interrupt request to host, active low |
| rx_rd_i | input | 1 | Core pops receive FIFO head |
| rx_data_o | output | 8 | Receive FIFO head byte |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_wr_i | input | 1 | Core pushes a byte into the transmit FIFO |
| tx_data_i | input | 8 | Byte to push |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |

## Verification
Each serial pin passes two synchronizer flops and one edge-detect flop, so a pin change takes effect on the third clock edge after it. The bench holds every serial level for eight clock cycles before it moves the clock again. It also samples sdo_o eight cycles after the falling edge that launched it, and checks interrupt and output-enable levels eight cycles after the serial edge that should change them. A core write reaches irq_no two edges later, so checks that follow a core write wait at least three cycles. The hold case pushes data between the 7th and 8th rising edges of a read byte and samples irq_no on both sides of the 8th edge.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BIT_CW = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } sspi_st_e;
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_act_o,
  output logic cs_start_o,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);
  // bit 2: cs, bit 1: sclk, bit 0: sdi
  localparam logic [2:0] RST_V = 3'b100;

  logic [2:0] stg_q [STAGES];
  logic [1:0] prev_q;
  logic [2:0] s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_V;
    end else begin
      stg_q[0] <= {cs_ni, sclk_i, sdi_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign s = stg_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_V[2:1];
    else         prev_q <= s[2:1];
  end

  assign cs_act_o   = ~s[2];
  assign cs_start_o = ~s[2] & prev_q[1];
  assign rise_o     =  s[1] & ~prev_q[0];
  assign fall_o     = ~s[1] &  prev_q[0];
  assign sdi_o      =  s[0];
endmodule

// File: rtl/sspi_fifo.sv
module sspi_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sspi_ctrl.sv
module sspi_ctrl
  import sspi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'h2A,
  parameter byte_t             FILL_BYTE = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_act_i,
  input  logic  cs_start_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  sdi_i,
  input  logic  rx_full_i,
  input  logic  tx_empty_i,
  input  byte_t tx_rdata_i,
  output logic  rx_push_o,
  output byte_t rx_wdata_o,
  output logic  rx_ovf_o,
  output logic  tx_pop_o,
  output logic  sdo_o,
  output logic  sdo_oe_o,
  output logic  irq_no,
  output logic  irq_hold_o
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);
  localparam logic [BIT_CW-1:0] DECIDE_BIT = BIT_CW'(BYTE_W - 2);

  sspi_st_e          st_q;
  logic [BIT_CW-1:0] bit_q;
  byte_t             in_q, out_q, byte_in;
  logic              sdo_q, done_q, irq_q, hold_q, ovf_q;
  logic              byte_end, addr_hit, load, release_irq;

  assign byte_in  = {in_q[BYTE_W-2:0], sdi_i};
  assign byte_end = cs_act_i & rise_i & (bit_q == LAST_BIT);
  assign addr_hit = (byte_in[BYTE_W-1:1] == DEV_ADDR);

  assign rx_push_o  = byte_end & (st_q == ST_WRITE) & ~rx_full_i;
  assign rx_wdata_o = byte_in;
  // next read byte is fetched at the last rising edge of the previous byte
  assign load = byte_end & ((st_q == ST_READ) |
                            ((st_q == ST_ADDR) & addr_hit & byte_in[0]));
  assign tx_pop_o = load & ~tx_empty_i & ~done_q;
  // end-of-message decision point
  assign release_irq = cs_act_i & rise_i & (st_q == ST_READ) &
                       (bit_q == DECIDE_BIT) & tx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      in_q   <= '0;
      done_q <= 1'b0;
    end else if (cs_start_i) begin
      st_q   <= ST_ADDR;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (!cs_act_i) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
    end else if (rise_i && st_q != ST_IDLE) begin
      in_q  <= byte_in;
      bit_q <= bit_q + 1'b1;
      if (release_irq) done_q <= 1'b1;
      if (bit_q == LAST_BIT && st_q == ST_ADDR) begin
        if (!addr_hit)       st_q <= ST_SKIP;
        else if (byte_in[0]) st_q <= ST_READ;
        else                 st_q <= ST_WRITE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      sdo_q <= 1'b0;
    end else if (cs_start_i) begin
      sdo_q <= 1'b0;
    end else if (load) begin
      out_q <= tx_pop_o ? tx_rdata_i : FILL_BYTE;
    end else if (fall_i && st_q == ST_READ) begin
      sdo_q <= out_q[BYTE_W-1];
      out_q <= {out_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b1;
      hold_q <= 1'b0;
    end else if (!irq_q) begin
      if (release_irq) begin
        irq_q  <= 1'b1;
        hold_q <= 1'b1;
      end
    end else if (hold_q) begin
      if (rise_i) hold_q <= 1'b0;
    end else if (!tx_empty_i) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (byte_end && st_q == ST_WRITE && rx_full_i) ovf_q <= 1'b1;
  end

  assign sdo_oe_o   = (st_q == ST_READ);
  assign sdo_o      = sdo_oe_o & sdo_q;
  assign irq_no     = irq_q;
  assign irq_hold_o = hold_q;
  assign rx_ovf_o   = ovf_q;
endmodule

// File: rtl/sspi_port.sv
module sspi_port
  import sspi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2A,
  parameter int unsigned       FIFO_DEPTH  = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter byte_t             FILL_BYTE   = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        sclk_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  output logic        irq_no,
  input  logic        rx_rd_i,
  output logic [7:0]  rx_data_o,
  output logic        rx_empty_o,
  output logic        rx_full_o,
  output logic        rx_ovf_o,
  input  logic        tx_wr_i,
  input  logic [7:0]  tx_data_i,
  output logic        tx_empty_o,
  output logic        tx_full_o
);
  logic  cs_act, cs_start, sclk_rise, sclk_fall, sdi_s;
  logic  rx_push, tx_pop, irq_hold;
  byte_t rx_wdata, tx_rdata;

  sspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i,
    .cs_act_o(cs_act), .cs_start_o(cs_start),
    .rise_o(sclk_rise), .fall_o(sclk_fall), .sdi_o(sdi_s)
  );

  sspi_ctrl #(.DEV_ADDR(DEV_ADDR), .FILL_BYTE(FILL_BYTE)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .cs_start_i(cs_start),
    .rise_i(sclk_rise), .fall_i(sclk_fall), .sdi_i(sdi_s),
    .rx_full_i(rx_full_o), .tx_empty_i(tx_empty_o), .tx_rdata_i(tx_rdata),
    .rx_push_o(rx_push), .rx_wdata_o(rx_wdata), .rx_ovf_o(rx_ovf_o),
    .tx_pop_o(tx_pop), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .irq_no(irq_no), .irq_hold_o(irq_hold)
  );

  sspi_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_wdata), .pop_i(rx_rd_i),
    .rdata_o(rx_data_o), .full_o(rx_full_o), .empty_o(rx_empty_o)
  );

  sspi_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_wr_i), .wdata_i(tx_data_i), .pop_i(tx_pop),
    .rdata_o(tx_rdata), .full_o(tx_full_o), .empty_o(tx_empty_o)
  );
endmodule

// File: rtl/sspi_port_chk.sv
module sspi_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act,
  input logic tx_pop,
  input logic rx_push,
  input logic irq_hold,
  input logic sdo_oe_o,
  input logic irq_no,
  input logic tx_empty_o,
  input logic tx_full_o,
  input logic rx_empty_o,
  input logic rx_full_o,
  input logic rx_ovf_o
);
  a_r9_oe_off_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !sdo_oe_o);

  a_r3_pop_only_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> cs_act && !tx_empty_o);

  a_r2_push_only_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> cs_act && !rx_full_o);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |=> rx_ovf_o);

  a_r10_tx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o));

  a_r10_rx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_o && rx_empty_o));

  a_r6_release_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(tx_empty_o));

  a_r7_hold_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hold |-> irq_no);
endmodule

bind sspi_port sspi_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_act(cs_act), .tx_pop(tx_pop),
  .rx_push(rx_push), .irq_hold(irq_hold), .sdo_oe_o(sdo_oe_o),
  .irq_no(irq_no), .tx_empty_o(tx_empty_o), .tx_full_o(tx_full_o),
  .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o), .rx_ovf_o(rx_ovf_o)
);

// File: tb/sspi_port_bench.sv
module sspi_port_bench;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int HB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic rx_rd = 1'b0, tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sdo, sdo_oe, irq_n, rx_empty, rx_full, rx_ovf, tx_empty, tx_full;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sspi_port #(.DEV_ADDR(ADDR)) u_sspi_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_no(irq_n),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .rx_full_o(rx_full), .rx_ovf_o(rx_ovf),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_empty_o(tx_empty), .tx_full_o(tx_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sdi = b;
    wait_clk(HB);
    r = sdo;
    sclk = 1'b1;
    wait_clk(HB);
    sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] o, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(o[i], r[i]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_clk(HB);
  endtask

  task automatic cs_hi();
    wait_clk(HB);
    cs_n = 1'b1;
    wait_clk(HB);
  endtask

  task automatic tx_push(input logic [7:0] b);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = b;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic rx_pop(output logic [7:0] b);
    @(negedge clk);
    b = rx_data;
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1 irq_no", irq_n, 1);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 full flags", {rx_full, tx_full}, 0);
    chk("R1 rx_ovf", rx_ovf, 0);
  endtask

  task automatic t_write();
    logic [7:0] r;
    cs_lo();
    spi_byte({ADDR, 1'b0}, r);
    chk("R2 no drive on write", sdo_oe, 0);
    spi_byte(8'hA5, r);
    spi_byte(8'h3C, r);
    cs_hi();
    chk("R2 rx not empty", rx_empty, 0);
    rx_pop(r); chk("R2 first byte", r, 8'hA5);
    rx_pop(r); chk("R2 second byte", r, 8'h3C);
    chk("R10 rx empty after drain", rx_empty, 1);
  endtask

  task automatic t_read();
    logic [7:0] r;
    tx_push(8'h96);
    wait_clk(3);
    chk("R5 irq low after core write", irq_n, 0);
    tx_push(8'h5B);
    cs_lo();
    spi_byte({ADDR, 1'b1}, r);
    chk("R3 sdo_oe in read", sdo_oe, 1);
    spi_byte(8'h00, r);
    chk("R3 read byte 0", r, 8'h96);
    chk("R6 irq stays low with data queued", irq_n, 0);
    spi_byte(8'h00, r);
    chk("R3 read byte 1", r, 8'h5B);
    chk("R6 irq released on empty", irq_n, 1);
    cs_hi();
    chk("R9 sdo_oe off after deselect", sdo_oe, 0);
    chk("R3 tx drained", tx_empty, 1);
  endtask

  task automatic t_hold();
    logic [7:0] r;
    logic b;
    tx_push(8'hC3);
    wait_clk(3);
    cs_lo();
    spi_byte({ADDR, 1'b1}, r);
    for (int i = 7; i >= 1; i--) spi_bit(1'b0, r[i]);
    chk("R6 irq high after 7th rise", irq_n, 1);
    tx_push(8'h11);
    wait_clk(4);
    chk("R7 irq held high before next rise", irq_n, 1);
    spi_bit(1'b0, b);
    r[0] = b;
    chk("R3 read byte C3", r, 8'hC3);
    chk("R7 irq low again after next rise", irq_n, 0);
    spi_byte(8'h00, r);
    chk("R7 filler after release", r, 8'h00);
    chk("R7 pending byte not popped", tx_empty, 0);
    cs_hi();
    cs_lo();
    spi_byte({ADDR, 1'b1}, r);
    spi_byte(8'h00, r);
    chk("R7 new read delivers pending", r, 8'h11);
    cs_hi();
    chk("R6 irq high at end", irq_n, 1);
  endtask

  task automatic t_ignore();
    logic [7:0] r;
    tx_push(8'h77);
    cs_lo();
    spi_byte({ADDR ^ 7'h01, 1'b1}, r);
    spi_byte(8'h00, r);
    chk("R4 no drive on foreign read", sdo_oe, 0);
    cs_hi();
    chk("R4 no pop on foreign read", tx_empty, 0);
    cs_lo();
    spi_byte({ADDR ^ 7'h10, 1'b0}, r);
    spi_byte(8'h55, r);
    cs_hi();
    chk("R4 no push on foreign write", rx_empty, 1);
    cs_lo();
    spi_byte({ADDR, 1'b1}, r);
    spi_byte(8'h00, r);
    cs_hi();
    chk("R4 queued byte intact", r, 8'h77);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    logic b;
    cs_lo();
    spi_byte({ADDR, 1'b0}, r);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, b);
    cs_hi();
    chk("R9 partial byte discarded", rx_empty, 1);
  endtask

  task automatic t_overflow();
    logic [7:0] r;
    cs_lo();
    spi_byte({ADDR, 1'b0}, r);
    for (int i = 0; i < 9; i++) spi_byte(8'h10 + 8'(i), r);
    cs_hi();
    chk("R10 rx full at depth", rx_full, 1);
    chk("R8 overflow set", rx_ovf, 1);
    for (int i = 0; i < 8; i++) begin
      rx_pop(r);
      chk("R8 kept bytes in order", r, 8'h10 + 8'(i));
    end
    chk("R8 ninth byte dropped", rx_empty, 1);
    chk("R8 overflow sticky", rx_ovf, 1);
  endtask

  task automatic t_txfull();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) tx_push(8'hA0 + 8'(i));
    chk("R10 tx full at depth", tx_full, 1);
    cs_lo();
    spi_byte({ADDR, 1'b1}, r);
    for (int i = 0; i < 8; i++) begin
      spi_byte(8'h00, r);
      chk("R3 burst byte", r, 8'hA0 + 8'(i));
    end
    chk("R6 irq released after last", irq_n, 1);
    cs_hi();
    chk("R10 tx empty after burst", {tx_empty, tx_full}, 2'b10);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_write();
    t_read();
    t_hold();
    t_ignore();
    t_abort();
    t_txfull();
    t_overflow();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule